// File: doc/BRIEF.md
# Combining Memory-to-I/O Bus Bridge

This bridge sits between a split-transaction memory bus and a connected-transaction I/O bus. Memory-bus masters hand it read and write requests, each tagged with a requester ID. The requests wait in a queue and go out to the I/O bus strictly in the order they arrived. A read keeps ownership of the I/O bus from the moment its request is accepted until its response has come back. A write gives the bus up as soon as its request has been taken, because no response follows.

Before each downstream transaction starts, the bridge looks at the head of the queue. It groups the head with every entry directly behind it that has the same kind and the same address. The whole group then goes out as one I/O transaction. A merged read answers every requester in the group, in arrival order, each with its own ID and the same data. A merged write sends the data of the youngest write in the group. The group is fixed when the transaction starts. Requests that arrive later are not added, even if they match.

Three interfaces use valid/ready: request in, I/O request out, and response out. A sender keeps valid and every payload field steady until ready is seen at a clock edge. The bridge never lowers `io_valid` or `rsp_valid`, and never changes their payload, while the matching ready is low. `req_ready` falls only when the queue is full. The I/O response is a single-cycle pulse that the bridge always accepts. `QDEPTH` must be a power of two and at least 2.

Top module: `merge_bridge`

## Requirements
- R1: Downstream transactions are issued in the order the requests were accepted, and a group only ever contains entries that sit next to each other in the queue.
- R2: `req_ready` is low exactly while `QDEPTH` requests are held, and it returns high once the queue drains.
- R3: After a read request is accepted on the I/O bus, `io_own` stays high and `io_valid` stays low until the read's response pulse has arrived.
- R4: In the cycle after a write is accepted on the I/O bus, `io_own` is low and no response is awaited.
- R5: Adjacent reads (`req_write`=0) to one address become one downstream read. Each requester in the group receives a response with its own ID and the returned data, in arrival order.
- R6: Adjacent writes (`req_write`=1) to one address become one downstream write, and its `io_data` is the data of the last write in the group.
- R7: A read and a write to the same address are never merged, and requests to different addresses are never merged.
- R8: During and right after reset, `req_ready` is 1 and `io_valid`, `rsp_valid` and `io_own` are 0.
- R9: While `io_ready` is low, `io_valid`, `io_write`, `io_addr` and `io_data` hold steady. While `rsp_ready` is low, `rsp_valid`, `rsp_id` and `rsp_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered by the memory bus |
| req_ready | output | 1 | Queue can take a request (low when full) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | Write data (ignored for reads) |
| req_id | input | ID_W | Requester ID |
| io_valid | output | 1 | I/O request offered |
| io_ready | input | 1 | I/O bus takes the request |
| io_write | output | 1 | I/O request kind |
| io_addr | output | ADDR_W | I/O request address |
| io_data | output | DATA_W | I/O write data (zero for reads) |
| io_own | output | 1 | Bridge holds the I/O bus |
| io_rsp_valid | input | 1 | Single-cycle read response pulse |
| io_rsp_data | input | DATA_W | Read response data |
| rsp_valid | output | 1 | Response offered to a requester |
| rsp_ready | input | 1 | Memory bus takes the response |
| rsp_id | output | ID_W | ID of the requester being answered |
| rsp_data | output | DATA_W | Response data |

## Verification
The bench first parks a lone read on the I/O bus by withholding its response. While that read waits, it fills the queue with three requests. It does this for all 64 combinations of kind (read or write) and of two addresses. Each pattern fixes a grouping that differs from the others: some have full runs, some have broken runs, some mix a read and a write on one address, and some alternate addresses. Counting and comparing the downstream transactions separates correct merging from missed merges and from merges that go too far. Comparing the response stream separates correct fan-out of IDs and data from lost or reordered replies. Every pattern is run a second time with both readies toggling each cycle, which shows whether payloads hold steady under back-pressure.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } mbr_state_e;
endpackage

// File: rtl/mbr_fifo.sv
module mbr_fifo #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int ID_W   = 3,
  parameter int QDEPTH = 4,
  localparam int PW    = $clog2(QDEPTH),
  localparam int CW    = $clog2(QDEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic                           push_wr,
  input  logic [ADDR_W-1:0]              push_addr,
  input  logic [DATA_W-1:0]              push_data,
  input  logic [ID_W-1:0]                push_id,
  input  logic [CW-1:0]                  pop_n,
  output logic                           full,
  output logic [CW-1:0]                  count,
  output logic [QDEPTH-1:0]              win_wr,
  output logic [QDEPTH-1:0][ADDR_W-1:0]  win_addr,
  output logic [QDEPTH-1:0][DATA_W-1:0]  win_data,
  output logic [QDEPTH-1:0][ID_W-1:0]    win_id
);
  logic              mem_wr   [QDEPTH];
  logic [ADDR_W-1:0] mem_addr [QDEPTH];
  logic [DATA_W-1:0] mem_data [QDEPTH];
  logic [ID_W-1:0]   mem_id   [QDEPTH];
  logic [PW-1:0]     rd_ptr, wr_ptr;

  assign full = (count == CW'(QDEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      rd_ptr <= rd_ptr + pop_n[PW-1:0];
      count  <= count + CW'(push) - pop_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_wr[wr_ptr]   <= push_wr;
      mem_addr[wr_ptr] <= push_addr;
      mem_data[wr_ptr] <= push_data;
      mem_id[wr_ptr]   <= push_id;
    end
  end

  // Window of entries in queue order, offset 0 being the oldest
  for (genvar k = 0; k < QDEPTH; k++) begin : g_win
    logic [PW-1:0] slot;
    assign slot        = rd_ptr + PW'(k);
    assign win_wr[k]   = mem_wr[slot];
    assign win_addr[k] = mem_addr[slot];
    assign win_data[k] = mem_data[slot];
    assign win_id[k]   = mem_id[slot];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(QDEPTH)); // R2
  AST_POP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pop_n <= count); // R1
endmodule

// File: rtl/mbr_scan.sv
module mbr_scan #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int QDEPTH = 4,
  localparam int CW    = $clog2(QDEPTH + 1)
) (
  input  logic [CW-1:0]                  count,
  input  logic [QDEPTH-1:0]              win_wr,
  input  logic [QDEPTH-1:0][ADDR_W-1:0]  win_addr,
  input  logic [QDEPTH-1:0][DATA_W-1:0]  win_data,
  output logic [CW-1:0]                  run_len,
  output logic [DATA_W-1:0]              last_data
);
  // Length of the same-kind, same-address run starting at the head
  always_comb begin
    logic alive;
    alive     = (count != '0);
    run_len   = alive ? CW'(1) : '0;
    last_data = win_data[0];
    for (int k = 1; k < QDEPTH; k++) begin
      alive = alive && (CW'(k) < count)
                    && (win_wr[k] == win_wr[0])
                    && (win_addr[k] == win_addr[0]);
      if (alive) begin
        run_len   = CW'(k + 1);
        last_data = win_data[k];
      end
    end
  end
endmodule

// File: rtl/mbr_ctrl.sv
module mbr_ctrl
  import mbr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int ID_W   = 3,
  parameter int QDEPTH = 4,
  localparam int PW    = $clog2(QDEPTH),
  localparam int CW    = $clog2(QDEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CW-1:0]                count,
  input  logic [CW-1:0]                run_len,
  input  logic [DATA_W-1:0]            last_data,
  input  logic                         head_wr,
  input  logic [ADDR_W-1:0]            head_addr,
  input  logic [QDEPTH-1:0][ID_W-1:0]  win_id,
  output logic [CW-1:0]                pop_n,
  output logic                         io_valid,
  input  logic                         io_ready,
  output logic                         io_write,
  output logic [ADDR_W-1:0]            io_addr,
  output logic [DATA_W-1:0]            io_data,
  output logic                         io_own,
  input  logic                         io_rsp_valid,
  input  logic [DATA_W-1:0]            io_rsp_data,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [ID_W-1:0]              rsp_id,
  output logic [DATA_W-1:0]            rsp_data
);
  mbr_state_e        state;
  logic [CW-1:0]     len_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [PW-1:0]     idx_q;
  logic              last_rsp;

  assign last_rsp = (CW'(idx_q) + CW'(1) == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      len_q  <= '0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      idx_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (count != '0) begin
          len_q  <= run_len;
          wr_q   <= head_wr;
          addr_q <= head_addr;
          data_q <= head_wr ? last_data : '0;
          state  <= ST_ISSUE;
        end
        ST_ISSUE: if (io_ready) state <= wr_q ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (io_rsp_valid) begin
          data_q <= io_rsp_data;
          idx_q  <= '0;
          state  <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) begin
          if (last_rsp) state <= ST_IDLE;
          else          idx_q <= idx_q + PW'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pop_n = '0;
    if (state == ST_ISSUE && io_ready && wr_q)        pop_n = len_q;
    if (state == ST_RESP && rsp_ready && last_rsp)    pop_n = len_q;
  end

  assign io_valid  = (state == ST_ISSUE);
  assign io_write  = wr_q;
  assign io_addr   = addr_q;
  assign io_data   = data_q;
  assign io_own    = (state == ST_ISSUE) || (state == ST_WAIT);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_id    = win_id[idx_q];
  assign rsp_data  = data_q;

  AST_IO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid && !io_ready |=> io_valid && $stable(io_addr) && $stable(io_write) && $stable(io_data)); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_id) && $stable(rsp_data)); // R9
  AST_READ_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid && io_ready && !io_write |=> !io_valid && io_own); // R3
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    io_own && !io_valid && !io_rsp_valid |=> io_own && !io_valid); // R3
  AST_WRITE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid && io_ready && io_write |=> !io_own && !rsp_valid); // R4
  AST_RSP_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !io_own); // R5
endmodule

// File: rtl/merge_bridge.sv
module merge_bridge #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int ID_W   = 3,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [ID_W-1:0]   req_id,
  output logic              io_valid,
  input  logic              io_ready,
  output logic              io_write,
  output logic [ADDR_W-1:0] io_addr,
  output logic [DATA_W-1:0] io_data,
  output logic              io_own,
  input  logic              io_rsp_valid,
  input  logic [DATA_W-1:0] io_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ID_W-1:0]   rsp_id,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int CW = $clog2(QDEPTH + 1);

  logic                          full, push;
  logic [CW-1:0]                 count, pop_n, run_len;
  logic [DATA_W-1:0]             last_data;
  logic [QDEPTH-1:0]             win_wr;
  logic [QDEPTH-1:0][ADDR_W-1:0] win_addr;
  logic [QDEPTH-1:0][DATA_W-1:0] win_data;
  logic [QDEPTH-1:0][ID_W-1:0]   win_id;

  assign req_ready = !full;
  assign push      = req_valid && !full;

  mbr_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .QDEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_wr(req_write), .push_addr(req_addr),
    .push_data(req_data), .push_id(req_id), .pop_n(pop_n), .full(full), .count(count),
    .win_wr(win_wr), .win_addr(win_addr), .win_data(win_data), .win_id(win_id)
  );

  mbr_scan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .QDEPTH(QDEPTH)) u_scan (
    .count(count), .win_wr(win_wr), .win_addr(win_addr), .win_data(win_data),
    .run_len(run_len), .last_data(last_data)
  );

  mbr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .QDEPTH(QDEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .count(count), .run_len(run_len), .last_data(last_data),
    .head_wr(win_wr[0]), .head_addr(win_addr[0]), .win_id(win_id), .pop_n(pop_n),
    .io_valid(io_valid), .io_ready(io_ready), .io_write(io_write), .io_addr(io_addr),
    .io_data(io_data), .io_own(io_own), .io_rsp_valid(io_rsp_valid),
    .io_rsp_data(io_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_id(rsp_id), .rsp_data(rsp_data)
  );

  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && pop_n == '0 |=> !req_ready); // R2
endmodule

// File: tb/test_merge_bridge.sv
module test_merge_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6, DW = 16, IW = 3, QD = 4;
  localparam logic [AW-1:0] ADDR_A = 6'h05, ADDR_B = 6'h0A, ADDR_BLK = 6'h3F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [IW-1:0] req_id = '0;
  logic io_valid, io_ready = 1, io_write, io_own;
  logic [AW-1:0] io_addr;
  logic [DW-1:0] io_data;
  logic io_rsp_valid = 0;
  logic [DW-1:0] io_rsp_data = '0;
  logic rsp_valid, rsp_ready = 1;
  logic [IW-1:0] rsp_id;
  logic [DW-1:0] rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  merge_bridge #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .QDEPTH(QD)) i_merge_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_data(req_data), .req_id(req_id),
    .io_valid(io_valid), .io_ready(io_ready), .io_write(io_write), .io_addr(io_addr),
    .io_data(io_data), .io_own(io_own), .io_rsp_valid(io_rsp_valid),
    .io_rsp_data(io_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_id(rsp_id), .rsp_data(rsp_data)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0, hold = 0, stall = 0, acc = 0, pend = 0, wrel = 0, prev_stall = 0;
  int lat = 0;
  logic [AW-1:0] pend_addr, prev_addr;

  int rec_io_n, rec_rsp_n, exp_io_n, exp_rsp_n;
  logic          rec_io_wr [16], exp_io_wr [16];
  logic [AW-1:0] rec_io_addr [16], exp_io_addr [16];
  logic [DW-1:0] rec_io_data [16], exp_io_data [16];
  logic [IW-1:0] rec_rsp_id [16], exp_rsp_id [16];
  logic [DW-1:0] rec_rsp_data [16], exp_rsp_data [16];

  function automatic logic [DW-1:0] rd_val(logic [AW-1:0] a);
    return DW'(a) * 16'd97 + 16'h0200;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    if (io_valid && io_ready && rec_io_n < 16) begin
      rec_io_wr[rec_io_n] = io_write; rec_io_addr[rec_io_n] = io_addr;
      rec_io_data[rec_io_n] = io_data; rec_io_n++;
      if (!io_write) begin pend = 1; lat = 2; pend_addr = io_addr; end
      else wrel = 1;
    end
    if (rsp_valid && rsp_ready && rec_rsp_n < 16) begin
      rec_rsp_id[rec_rsp_n] = rsp_id; rec_rsp_data[rec_rsp_n] = rsp_data; rec_rsp_n++;
    end
    acc = req_valid && req_ready;
    prev_stall = io_valid && !io_ready;
    prev_addr = io_addr;
    @(negedge clk);
    cyc++;
    if (wrel) begin
      chk(!io_own, "R4", "io_own after write accept", int'(io_own), 0);
      wrel = 0;
    end
    if (prev_stall)
      chk(io_valid && io_addr == prev_addr, "R9", "io request held under stall",
          int'(io_addr), int'(prev_addr));
    io_rsp_valid = 0;
    if (pend && !hold) begin
      if (lat == 0) begin io_rsp_valid = 1; io_rsp_data = rd_val(pend_addr); pend = 0; end
      else lat--;
    end
    io_ready  = stall ? cyc[0] : 1'b1;
    rsp_ready = stall ? ~cyc[0] : 1'b1;
  endtask

  task automatic push(logic wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [IW-1:0] id);
    req_write = wr; req_addr = a; req_data = d; req_id = id; req_valid = 1;
    do tick(); while (!acc);
    req_valid = 0;
  endtask

  task automatic run_pattern(int p);
    logic pw; logic [AW-1:0] pa;
    rec_io_n = 0; rec_rsp_n = 0;
    exp_io_n = 1; exp_io_wr[0] = 0; exp_io_addr[0] = ADDR_BLK; exp_io_data[0] = '0;
    exp_rsp_n = 1; exp_rsp_id[0] = 0; exp_rsp_data[0] = rd_val(ADDR_BLK);
    pw = 0; pa = '0;
    for (int k = 0; k < 3; k++) begin
      logic wr; logic [AW-1:0] ad; logic [DW-1:0] d;
      wr = p[2*k]; ad = p[2*k+1] ? ADDR_B : ADDR_A; d = DW'(16'h0100 * (k + 1) + p);
      if (k == 0 || wr != pw || ad != pa) begin
        exp_io_wr[exp_io_n] = wr; exp_io_addr[exp_io_n] = ad;
        exp_io_data[exp_io_n] = wr ? d : '0; exp_io_n++;
      end else if (wr) exp_io_data[exp_io_n-1] = d;
      if (!wr) begin
        exp_rsp_id[exp_rsp_n] = IW'(k + 1); exp_rsp_data[exp_rsp_n] = rd_val(ad); exp_rsp_n++;
      end
      pw = wr; pa = ad;
    end
    hold = 1;
    push(1'b0, ADDR_BLK, 16'h0, 3'd0);
    for (int k = 0; k < 3; k++)
      push(p[2*k], p[2*k+1] ? ADDR_B : ADDR_A, DW'(16'h0100 * (k + 1) + p), IW'(k + 1));
    tick(); tick();
    chk(!req_ready, "R2", "req_ready with queue full", int'(req_ready), 0);
    chk(io_own && !io_valid, "R3", "bus held while read waits", int'(io_own), 1);
    chk(rec_io_n == 1, "R3", "no second I/O request before response", rec_io_n, 1);
    hold = 0;
    for (int t = 0; t < 200; t++) begin
      tick();
      if (rec_rsp_n >= exp_rsp_n && rec_io_n >= exp_io_n && !io_own && !rsp_valid) break;
    end
    for (int t = 0; t < 4; t++) tick();
    chk(rec_io_n == exp_io_n, "R7", $sformatf("downstream count p=%0d", p), rec_io_n, exp_io_n);
    for (int i = 0; i < exp_io_n && i < rec_io_n; i++) begin
      chk(rec_io_wr[i] == exp_io_wr[i] && rec_io_addr[i] == exp_io_addr[i], "R1",
          $sformatf("order p=%0d txn %0d", p, i),
          int'({rec_io_wr[i], rec_io_addr[i]}), int'({exp_io_wr[i], exp_io_addr[i]}));
      if (exp_io_wr[i])
        chk(rec_io_data[i] == exp_io_data[i], "R6", $sformatf("merged write data p=%0d", p),
            int'(rec_io_data[i]), int'(exp_io_data[i]));
    end
    chk(rec_rsp_n == exp_rsp_n, "R5", $sformatf("response count p=%0d", p), rec_rsp_n, exp_rsp_n);
    for (int i = 0; i < exp_rsp_n && i < rec_rsp_n; i++)
      chk(rec_rsp_id[i] == exp_rsp_id[i] && rec_rsp_data[i] == exp_rsp_data[i], "R5",
          $sformatf("response p=%0d idx %0d", p, i),
          int'({rec_rsp_id[i], rec_rsp_data[i]}), int'({exp_rsp_id[i], exp_rsp_data[i]}));
    chk(req_ready && !io_own, "R2", "queue drained", int'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !io_valid && !rsp_valid && !io_own, "R8", "reset outputs",
        int'({req_ready, io_valid, rsp_valid, io_own}), 8);
    rst_n = 1;
    tick();
    chk(req_ready && !io_valid && !rsp_valid && !io_own, "R8", "after reset",
        int'({req_ready, io_valid, rsp_valid, io_own}), 8);
    for (int m = 0; m < 2; m++) begin
      stall = (m == 1);
      for (int p = 0; p < 64; p++) run_pattern(p);
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule